// File: doc/BRIEF.md
# Centre-Spread Triangle Dither Generator

This block produces a digital triangle-wave modulation word for a numerically controlled master clock. Each clock cycle it outputs a signed frequency offset, expressed as a fraction of the centre increment. The offset swings equally above and below zero, so the dithered clock spreads its energy around the programmed centre frequency without moving the average. An oscillator model adds the offset to its nominal phase increment, which gives a spread-spectrum clock.

Two controls set the modulation. A 2-bit rate code selects a period of 2^B, 2^(B+1) or 2^(B+2) master cycles, where B is `BASE_LOG2`, or turns dither off. A 2-bit depth code selects a peak deviation of 1, 2, 4 or 8 percent. An enable pin gates the whole function. When dither is off, the offset is held at exactly zero. Whenever dither starts, the triangle restarts from its zero crossing.

Top module: `spread_dither_gen`

## Requirements
- R1: Dither runs only when `spread_en` is 1 and `rate_sel` is nonzero, as sampled at a rising clock edge. In every other case, `freq_offset` is 0 after that edge.
- R2: The phase advances by one per clock and wraps after P cycles. P is 2^B for `rate_sel`=01, 2^(B+1) for 10 and 2^(B+2) for 11, where B is `BASE_LOG2`. With the default B of 11, these periods are 2048, 4096 and 8192.
- R3: The peak magnitude is round(pct·2^F/100). Here pct is 1, 2, 4 or 8 for `amp_sel`=00, 01, 10 or 11, and F is `FRAC_W`. With the default F of 16, the peaks are 655, 1311, 2621 and 5243. `|freq_offset|` never exceeds this peak.
- R4: Let Q = P/4 and let p be the phase. Then t = p for p<Q, t = 2Q−p for p<3Q, and t = p−4Q otherwise. The output is sign(t)·floor(|t|·peak/Q). The offset therefore reaches +peak at p=Q and −peak at p=3Q.
- R5: The offset at phase p+P/2 is the negation of the offset at phase p. As a result, the offsets summed over one whole period equal 0.
- R6: The phase restarts at 0, with the offset at 0, on the first edge at which dither becomes active. It also restarts on any edge at which `rate_sel` differs from its value at the previous edge while dither stays active.
- R7: A change of `amp_sel` rescales the offset at once and does not restart the phase.
- R8: While `rst_n` is low, the generator is inactive, its phase is 0 and `freq_offset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Dither enable pin |
| rate_sel | input | 2 | Modulation period code (00 = off) |
| amp_sel | input | 2 | Peak deviation code |
| freq_offset | output | FRAC_W | Signed offset, FRAC_W fraction bits of the centre increment |

## Verification
Three events can coincide with the phase counter. A rate change can land on the same edge as a normal advance. An enable edge can land on the same edge as a rate change. A depth change can arrive partway through a ramp, where it rescales the current phase value. The bench provokes each of these cases at a chosen phase. It switches the rate after ten cycles of a run and checks that the next sample sits at phase 0 of the new period. It then changes the depth at phase 20 and checks that the following samples follow the new peak at phases 21 onward, with no restart. The bench computes each expected value from the piecewise triangle formula, so a sample taken at the wrong phase or with the wrong scale shows up as a mismatch.

// File: rtl/dither_pkg.sv
package dither_pkg;

  // Percent of deviation selected by the depth code: 1, 2, 4 or 8.
  function automatic int amp_percent(input logic [1:0] amp);
    return 1 << amp;
  endfunction

  // Peak magnitude in fixed point with frac_w fraction bits, rounded.
  function automatic int peak_code(input logic [1:0] amp, input int frac_w);
    return ((amp_percent(amp) << frac_w) + 50) / 100;
  endfunction

  // log2 of the modulation period for a nonzero rate code.
  function automatic int period_log2(input logic [1:0] rate, input int base_log2);
    return base_log2 + int'(rate) - 1;
  endfunction

  // Triangle numerator in the range -Q..Q, with Q = 2**qlog.
  function automatic int tri_value(input int ph, input int qlog);
    int q;
    q = 1 << qlog;
    if (ph < q)          return ph;
    else if (ph < 3 * q) return 2 * q - ph;
    else                 return ph - 4 * q;
  endfunction

  // Symmetric scaling: the magnitude is floored and the sign reapplied.
  function automatic int scale_tri(input int t, input int peak, input int qlog);
    int mag;
    mag = (t < 0) ? -t : t;
    mag = (mag * peak) >> qlog;
    return (t < 0) ? -mag : mag;
  endfunction

endpackage

// File: rtl/dither_mode_decode.sv
module dither_mode_decode
  import dither_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int PH_W      = BASE_LOG2 + 2
) (
  input  logic            spread_en,
  input  logic [1:0]      rate_sel,
  output logic            run_req,
  output logic [PH_W-1:0] last_phase
);
  int plen;

  always_comb begin
    run_req    = spread_en && (rate_sel != 2'b00);
    plen       = 1 << period_log2(rate_sel, BASE_LOG2);
    last_phase = PH_W'(plen - 1);
  end
endmodule

// File: rtl/dither_phase_ctr.sv
module dither_phase_ctr #(
  parameter int PH_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_req,
  input  logic [1:0]      rate_sel,
  input  logic [PH_W-1:0] last_phase,
  output logic            active,
  output logic [1:0]      rate_q,
  output logic [PH_W-1:0] phase
);
  logic restart;
  logic advance;
  logic wrap;

  assign restart = run_req && (!active || (rate_sel != rate_q));
  assign advance = run_req && !restart;
  assign wrap    = advance && (phase == last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rate_q <= 2'b00;
      phase  <= '0;
    end else begin
      active <= run_req;
      rate_q <= rate_sel;
      if (!advance || wrap) phase <= '0;
      else                  phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/dither_scale.sv
module dither_scale
  import dither_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int FRAC_W    = 16,
  parameter int PH_W      = BASE_LOG2 + 2,
  parameter int OFS_W     = FRAC_W
) (
  input  logic                    active,
  input  logic [1:0]              rate_q,
  input  logic [1:0]              amp_sel,
  input  logic [PH_W-1:0]         phase,
  output logic [OFS_W-1:0]        crest_code,
  output logic signed [OFS_W-1:0] freq_offset
);
  int qlog;
  int peak;
  int tval;
  int sval;

  always_comb begin
    qlog        = period_log2(rate_q, BASE_LOG2) - 2;
    peak        = peak_code(amp_sel, FRAC_W);
    tval        = tri_value(int'(phase), qlog);
    sval        = scale_tri(tval, peak, qlog);
    crest_code  = OFS_W'(peak);
    freq_offset = active ? OFS_W'(sval) : '0;
  end
endmodule

// File: rtl/spread_dither_gen.sv
module spread_dither_gen #(
  parameter int BASE_LOG2 = 11,
  parameter int FRAC_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spread_en,
  input  logic [1:0]               rate_sel,
  input  logic [1:0]               amp_sel,
  output logic signed [FRAC_W-1:0] freq_offset
);
  localparam int PH_W  = BASE_LOG2 + 2;
  localparam int OFS_W = FRAC_W;

  logic            run_req;
  logic [PH_W-1:0] last_phase;
  logic            active;
  logic [1:0]      rate_q;
  logic [PH_W-1:0] phase;
  logic [OFS_W-1:0] crest_code;

  dither_mode_decode #(.BASE_LOG2(BASE_LOG2), .PH_W(PH_W)) u_decode (
    .spread_en (spread_en),
    .rate_sel  (rate_sel),
    .run_req   (run_req),
    .last_phase(last_phase)
  );

  dither_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .rate_sel  (rate_sel),
    .last_phase(last_phase),
    .active    (active),
    .rate_q    (rate_q),
    .phase     (phase)
  );

  dither_scale #(
    .BASE_LOG2(BASE_LOG2), .FRAC_W(FRAC_W), .PH_W(PH_W), .OFS_W(OFS_W)
  ) u_scale (
    .active     (active),
    .rate_q     (rate_q),
    .amp_sel    (amp_sel),
    .phase      (phase),
    .crest_code (crest_code),
    .freq_offset(freq_offset)
  );
endmodule

// File: rtl/spread_dither_chk.sv
module spread_dither_chk
  import dither_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int FRAC_W    = 16,
  parameter int PH_W      = BASE_LOG2 + 2,
  parameter int OFS_W     = FRAC_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    active,
  input logic [1:0]              rate_q,
  input logic [PH_W-1:0]         phase,
  input logic [OFS_W-1:0]        crest,
  input logic signed [OFS_W-1:0] freq_offset
);
  logic [PH_W-1:0] quarter;
  logic [PH_W-1:0] final_ph;
  logic signed [OFS_W:0] crest_s;

  always_comb begin
    quarter  = PH_W'(1 << (period_log2(rate_q, BASE_LOG2) - 2));
    final_ph = PH_W'((1 << period_log2(rate_q, BASE_LOG2)) - 1);
    crest_s  = $signed({1'b0, crest});
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> freq_offset == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (freq_offset <= crest_s) && (freq_offset >= -crest_s));

  // R4
  crest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase == quarter) |-> freq_offset == crest_s);

  // R5
  trough_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase == 3 * quarter) |-> freq_offset == -crest_s);

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (phase == '0) && (freq_offset == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $stable(rate_q) && phase != '0)
      |-> phase == $past(phase) + PH_W'(1));

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $stable(rate_q) && phase == '0)
      |-> $past(phase) == final_ph);
endmodule

bind spread_dither_gen spread_dither_chk #(
  .BASE_LOG2(BASE_LOG2), .FRAC_W(FRAC_W), .PH_W(PH_W), .OFS_W(OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .rate_q     (rate_q),
  .phase      (phase),
  .crest      (crest_code),
  .freq_offset(freq_offset)
);

// File: tb/spread_dither_gen_bench.sv
module spread_dither_gen_bench;
  localparam int BASE = 6;
  localparam int FRAC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spread_en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] amp_sel = 2'b00;
  logic signed [FRAC-1:0] freq_offset;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spread_dither_gen #(.BASE_LOG2(BASE), .FRAC_W(FRAC)) u_spread_dither_gen (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en),
    .rate_sel(rate_sel), .amp_sel(amp_sel), .freq_offset(freq_offset)
  );

  function automatic int period_of(input int rate);
    return 1 << (BASE + rate - 1);
  endfunction

  function automatic int peak_of(input int amp);
    int pct;
    pct = 1;
    for (int i = 0; i < amp; i++) pct = pct * 2;
    return (pct * (1 << FRAC) + 50) / 100;
  endfunction

  function automatic int expect_off(input int rate, input int amp, input int p);
    int q, d, t, m;
    q = period_of(rate) / 4;
    if (p < 2 * q) begin
      d = p - q; if (d < 0) d = -d;
      t = q - d;
    end else begin
      d = p - 3 * q; if (d < 0) d = -d;
      t = d - q;
    end
    m = (t < 0) ? -t : t;
    m = (m * peak_of(amp)) / q;
    return (t < 0) ? -m : m;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset offset", int'(freq_offset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", int'(freq_offset), 0);

    // R1: enable with rate code 0, then rate without enable
    spread_en = 1'b1; rate_sel = 2'b00;
    repeat (20) begin @(negedge clk); check("R1 rate off", int'(freq_offset), 0); end
    spread_en = 1'b0; rate_sel = 2'b01;
    repeat (20) begin @(negedge clk); check("R1 enable low", int'(freq_offset), 0); end

    // Sweep of every rate and depth over two full periods
    for (int r = 1; r <= 3; r++) begin
      for (int a = 0; a < 4; a++) begin
        int plen, sum;
        plen = period_of(r);
        sum = 0;
        spread_en = 1'b0;
        @(negedge clk);
        check("R1 disabled", int'(freq_offset), 0);
        spread_en = 1'b1; rate_sel = 2'(r); amp_sel = 2'(a);
        for (int n = 0; n < 2 * plen; n++) begin
          int p;
          @(negedge clk);
          p = n % plen;
          check("R4 shape", int'(freq_offset), expect_off(r, a, p));
          if (p == plen / 4) check("R3 peak", int'(freq_offset), peak_of(a));
          if (p == 3 * plen / 4) check("R5 trough", int'(freq_offset), -peak_of(a));
          if (n == plen) check("R2 period wrap", int'(freq_offset), 0);
          sum += int'(freq_offset);
          if (p == plen - 1) begin
            check("R5 period sum", sum, 0);
            sum = 0;
          end
        end
      end
    end

    // R6: rate change while running restarts the triangle
    spread_en = 1'b0;
    @(negedge clk);
    spread_en = 1'b1; rate_sel = 2'b01; amp_sel = 2'b01;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); check("R6 pre-switch", int'(freq_offset), expect_off(1, 1, n));
    end
    rate_sel = 2'b10;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk); check("R6 rate switch", int'(freq_offset), expect_off(2, 1, n));
    end

    // R6: re-enable restarts from zero
    spread_en = 1'b0;
    @(negedge clk);
    check("R1 disable mid-ramp", int'(freq_offset), 0);
    spread_en = 1'b1;
    for (int n = 0; n <= 20; n++) begin
      @(negedge clk); check("R6 re-enable", int'(freq_offset), expect_off(2, 1, n));
    end

    // R7: depth change keeps the phase running
    amp_sel = 2'b11;
    for (int n = 21; n < 60; n++) begin
      @(negedge clk); check("R7 depth change", int'(freq_offset), expect_off(2, 3, n));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule